// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps every instruction that has issued but not yet retired in a circular queue ordered as the program issued them. Issue claims the slot at the tail, and that slot's index becomes the rename tag for the instruction's destination register. Execution units send finished results over a shared result bus that carries this tag. The matching slot holds the value until the instruction reaches the head. Because architectural registers and the store path are updated only from the head, they always change in program order.

A small register status table records, for each architectural register, whether a buffered instruction will produce its value and which slot that is. Issue logic reads this table through a lookup port. The same port also reports a value that has finished but not yet retired. When the head slot has finished and is marked as a wrong-path branch or a faulting instruction, the block retires nothing in that cycle. It raises a one-cycle flush, which empties the queue and the register status table and tells the surrounding pipeline to discard its own state.

Top module: `inorder_retire_buf`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty, `occupancy` is 0, `alloc_ready` is 1, `cmt_valid` and `flush` are 0, and no register reads as busy.
- R2: Each accepted allocation gets the tail slot index on `alloc_tag`. Indices count 0 to DEPTH-1 and then wrap to 0. With DEPTH (8) slots occupied, `alloc_ready` is 0 and a request is ignored: occupancy does not change and no register is renamed.
- R3: An accepted allocation with `alloc_is_store`=0 makes its destination register read busy with the new slot index as its tag. An allocation with `alloc_is_store`=1 renames nothing.
- R4: A result-bus write to an occupied slot stores the value and marks the slot finished. A lookup of a register renamed to that slot then shows `lk_ready`=1 and the value, and the register still reads busy with the same tag.
- R5: Retirement happens only from the head, one slot per cycle, and only once the head has finished. Finished slots behind an unfinished head wait, and they retire in consecutive slot order.
- R6: In a retiring cycle, `cmt_valid`=1 and `cmt_tag`, `cmt_dest`, `cmt_value` and `cmt_is_store` describe the head slot. That slot is then freed.
- R7: Retirement clears a register's busy state only if the register's tag still equals the retiring slot index. A later rename of the same register stays busy.
- R8: An allocation and a retirement in the same cycle leave `occupancy` unchanged.
- R9: A finished head marked mispredicted (`cdb_mispredict`) or faulting (`cdb_exception`) raises `flush` for one cycle, with `cmt_valid`=0 and `alloc_ready`=0. Any allocation in that cycle is dropped. The next cycle has `occupancy` 0, no register busy, and slot index 0 for the next allocation.
- R10: A result-bus write to a slot that is not occupied is ignored. That slot later allocates as unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Issue requests a slot |
| alloc_dest | input | REG_W | Destination architectural register |
| alloc_is_store | input | 1 | Instruction is a store (no register rename) |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | IDX_W | Slot index given to the request |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | IDX_W | Slot index of the result |
| cdb_value | input | DATA_W | Result value |
| cdb_mispredict | input | 1 | Result is from a wrong-path branch |
| cdb_exception | input | 1 | Result carries a fault |
| lk_reg | input | REG_W | Register looked up by issue |
| lk_busy | output | 1 | Register awaits a buffered result |
| lk_tag | output | IDX_W | Slot that will produce the register |
| lk_ready | output | 1 | That slot has finished |
| lk_value | output | DATA_W | Buffered value of that slot |
| cmt_valid | output | 1 | Head retires this cycle |
| cmt_tag | output | IDX_W | Index of the retiring slot |
| cmt_dest | output | REG_W | Register to write |
| cmt_value | output | DATA_W | Value to write or store |
| cmt_is_store | output | 1 | Retiring slot is a store |
| flush | output | 1 | Discard all speculative state |
| occupancy | output | CNT_W | Slots currently held |

## Verification
The queue is filled to capacity and results arrive in reverse order. Nothing should retire until the head finishes, and then all eight slots should drain in order on consecutive cycles. This separates head-gated retirement from retiring whatever finished first. Two renames of the same register show whether retirement checks the tag before clearing busy state. A combined allocate-and-retire cycle separates count arithmetic that handles both at once from arithmetic that handles only one. Stray bus writes to empty slots, and flushes caused by a misprediction and by a fault with allocation attempted in the flush cycle, probe the recovery paths and the return to slot 0.

// File: rtl/inorder_retire_pkg.sv
// Package: shared types for the in-order retirement buffer.
// Assumes: nothing beyond standard SystemVerilog.
package inorder_retire_pkg;

    // What the head slot does in the current cycle.
    typedef enum logic [1:0] {
        RK_IDLE   = 2'd0,
        RK_RETIRE = 2'd1,
        RK_FLUSH  = 2'd2
    } retire_kind_e;

endpackage

// File: rtl/irb_ptrs.sv
// Module: head/tail pointers and occupancy count of the circular queue.
// Assumes: push is never asserted while full and pop never while empty
// (the top gates both); clear overrides both and returns to slot 0.
module irb_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    // Advance pointers and adjust the count for this cycle's push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= (tail == LAST) ? '0 : tail + 1'b1;
            if (pop)  head <= (head == LAST) ? '0 : head + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Status flags from the count.
    assign full  = (count == CAP);
    assign empty = (count == '0);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);
    p_hold_on_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clear) |=> (count == $past(count)));
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && tail == '0 && head == '0));

endmodule

// File: rtl/irb_slots.sv
// Module: per-slot storage of the retirement buffer (state, destination,
// result) with result-bus capture, head read-out and lookup by slot index.
// Assumes: push_idx is a free slot; pop_idx is an occupied finished slot.
module irb_slots #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [REG_W-1:0]  push_dest,
    input  logic              push_store,
    input  logic              pop,
    input  logic [IDX_W-1:0]  pop_idx,
    input  logic              cdb_valid,
    input  logic [IDX_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              cdb_bad,
    output logic              head_done,
    output logic              head_bad,
    output logic              head_store,
    output logic [REG_W-1:0]  head_dest,
    output logic [DATA_W-1:0] head_value,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_done,
    output logic [DATA_W-1:0] lk_value
);
    logic [DEPTH-1:0] valid_q, done_q, bad_q, store_q;
    logic [REG_W-1:0]  dest_q [DEPTH];
    logic [DATA_W-1:0] val_q  [DEPTH];
    logic [DEPTH-1:0] alloc_hit, free_hit, cdb_hit;

    // Per-slot decode of which operation touches each slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        assign alloc_hit[i] = push && (push_idx == IDX_W'(i));
        assign free_hit[i]  = pop && (pop_idx == IDX_W'(i));
        assign cdb_hit[i]   = cdb_valid && valid_q[i] && (cdb_tag == IDX_W'(i));
    end

    // Update every slot: allocate, capture a result, or free.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n || clear) begin
                valid_q[i] <= 1'b0;
                done_q[i]  <= 1'b0;
                bad_q[i]   <= 1'b0;
                store_q[i] <= 1'b0;
                dest_q[i]  <= '0;
                val_q[i]   <= '0;
            end else if (alloc_hit[i]) begin
                valid_q[i] <= 1'b1;
                done_q[i]  <= 1'b0;
                bad_q[i]   <= 1'b0;
                store_q[i] <= push_store;
                dest_q[i]  <= push_dest;
                val_q[i]   <= '0;
            end else begin
                if (cdb_hit[i]) begin
                    done_q[i] <= 1'b1;
                    bad_q[i]  <= cdb_bad;
                    val_q[i]  <= cdb_value;
                end
                if (free_hit[i]) begin
                    valid_q[i] <= 1'b0;
                    done_q[i]  <= 1'b0;
                end
            end
        end
    end

    // Head slot read-out for retirement.
    assign head_done  = valid_q[pop_idx] && done_q[pop_idx];
    assign head_bad   = bad_q[pop_idx];
    assign head_store = store_q[pop_idx];
    assign head_dest  = dest_q[pop_idx];
    assign head_value = val_q[pop_idx];

    // Operand lookup by slot index.
    assign lk_done  = valid_q[lk_idx] && done_q[lk_idx];
    assign lk_value = val_q[lk_idx];

    p_cdb_captures_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && valid_q[cdb_tag] && !clear && !(pop && pop_idx == cdb_tag))
        |=> (done_q[$past(cdb_tag)] && val_q[$past(cdb_tag)] == $past(cdb_value)));
    p_stray_write_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && !valid_q[cdb_tag]) |=> !done_q[$past(cdb_tag)]);

endmodule

// File: rtl/irb_status.sv
// Module: register status table mapping each architectural register to the
// slot that will produce it. A rename overrides a release in the same cycle.
// Assumes: set and clear are never asserted together by the top.
module irb_status #(
    parameter int NREG  = 32,
    parameter int IDX_W = 3,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [IDX_W-1:0] set_tag,
    input  logic             rel_en,
    input  logic [REG_W-1:0] rel_reg,
    input  logic [IDX_W-1:0] rel_tag,
    input  logic [REG_W-1:0] q_reg,
    output logic             q_busy,
    output logic [IDX_W-1:0] q_tag
);
    logic [NREG-1:0]  busy_q;
    logic [IDX_W-1:0] tag_q [NREG];
    logic [NREG-1:0]  set_hit, rel_hit;

    // Per-register decode of rename and release.
    for (genvar r = 0; r < NREG; r++) begin : g_dec
        assign set_hit[r] = set_en && (set_reg == REG_W'(r));
        assign rel_hit[r] = rel_en && (rel_reg == REG_W'(r));
    end

    // Rename on issue, release on retirement only if the tag still matches.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n || clear) begin
                busy_q[r] <= 1'b0;
                tag_q[r]  <= '0;
            end else if (set_hit[r]) begin
                busy_q[r] <= 1'b1;
                tag_q[r]  <= set_tag;
            end else if (rel_hit[r] && tag_q[r] == rel_tag) begin
                busy_q[r] <= 1'b0;
            end
        end
    end

    // Lookup for issue.
    assign q_busy = busy_q[q_reg];
    assign q_tag  = tag_q[q_reg];

    p_alloc_renames_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clear) |=> (busy_q[$past(set_reg)] && tag_q[$past(set_reg)] == $past(set_tag)));
    p_stale_release_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_en && !clear && !set_en && busy_q[rel_reg] && tag_q[rel_reg] != rel_tag)
        |=> busy_q[$past(rel_reg)]);
    p_flush_clears_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (busy_q == '0));

endmodule

// File: rtl/inorder_retire_buf.sv
// Module: top of the in-order retirement buffer. Allocates slots at issue,
// captures tagged results, retires finished heads in order, and flushes on a
// finished head that is wrong-path or faulting.
// Assumes: at most one allocation and one result-bus write per cycle.
module inorder_retire_buf
    import inorder_retire_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int NREG   = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic              alloc_is_store,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_tag,
    input  logic              cdb_valid,
    input  logic [IDX_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              cdb_mispredict,
    input  logic              cdb_exception,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_busy,
    output logic [IDX_W-1:0]  lk_tag,
    output logic              lk_ready,
    output logic [DATA_W-1:0] lk_value,
    output logic              cmt_valid,
    output logic [IDX_W-1:0]  cmt_tag,
    output logic [REG_W-1:0]  cmt_dest,
    output logic [DATA_W-1:0] cmt_value,
    output logic              cmt_is_store,
    output logic              flush,
    output logic [CNT_W-1:0]  occupancy
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] head_ptr, tail_ptr;
    logic             full, empty, push, pop;
    logic             head_done, head_bad, head_store, slot_lk_done;
    logic [REG_W-1:0] head_dest;
    retire_kind_e     kind;

    // Decide what the head does this cycle.
    always_comb begin
        kind = RK_IDLE;
        if (!empty && head_done) kind = head_bad ? RK_FLUSH : RK_RETIRE;
    end

    // Issue acceptance and retirement handshakes.
    assign flush       = (kind == RK_FLUSH);
    assign alloc_ready = !full && !flush;
    assign push        = alloc_req && alloc_ready;
    assign pop         = (kind == RK_RETIRE);
    assign alloc_tag   = tail_ptr;

    irb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .clear(flush), .push(push), .pop(pop),
        .head(head_ptr), .tail(tail_ptr), .count(occupancy),
        .full(full), .empty(empty)
    );

    irb_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .push(push), .push_idx(tail_ptr), .push_dest(alloc_dest),
        .push_store(alloc_is_store),
        .pop(pop), .pop_idx(head_ptr),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_bad(cdb_mispredict || cdb_exception),
        .head_done(head_done), .head_bad(head_bad), .head_store(head_store),
        .head_dest(head_dest), .head_value(cmt_value),
        .lk_idx(lk_tag), .lk_done(slot_lk_done), .lk_value(lk_value)
    );

    irb_status #(.NREG(NREG), .IDX_W(IDX_W)) u_status (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .set_en(push && !alloc_is_store), .set_reg(alloc_dest), .set_tag(tail_ptr),
        .rel_en(pop && !head_store), .rel_reg(head_dest), .rel_tag(head_ptr),
        .q_reg(lk_reg), .q_busy(lk_busy), .q_tag(lk_tag)
    );

    // Retirement port and lookup readiness.
    assign cmt_valid    = pop;
    assign cmt_tag      = head_ptr;
    assign cmt_dest     = head_dest;
    assign cmt_is_store = head_store;
    assign lk_ready     = lk_busy && slot_lk_done;

    p_commit_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> (!cmt_valid || cmt_tag == (($past(cmt_tag) == LAST) ? '0 : $past(cmt_tag) + 1'b1)));
    p_flush_blocks_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!cmt_valid && !alloc_ready));
    p_flush_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

endmodule

// File: tb/inorder_retire_buf_bench.sv
`timescale 1ns/1ps
// Bench: directed sweeps over an 8-slot buffer with expected values derived
// from slot arithmetic (index = allocation order mod 8).
module inorder_retire_buf_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req, alloc_is_store;
    logic [4:0]  alloc_dest;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        cdb_valid, cdb_mispredict, cdb_exception;
    logic [2:0]  cdb_tag;
    logic [31:0] cdb_value;
    logic [4:0]  lk_reg;
    logic        lk_busy, lk_ready;
    logic [2:0]  lk_tag;
    logic [31:0] lk_value;
    logic        cmt_valid, cmt_is_store, flush;
    logic [2:0]  cmt_tag;
    logic [4:0]  cmt_dest;
    logic [31:0] cmt_value;
    logic [3:0]  occupancy;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    inorder_retire_buf u_inorder_retire_buf (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_dest(alloc_dest), .alloc_is_store(alloc_is_store),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_mispredict(cdb_mispredict), .cdb_exception(cdb_exception),
        .lk_reg(lk_reg), .lk_busy(lk_busy), .lk_tag(lk_tag),
        .lk_ready(lk_ready), .lk_value(lk_value),
        .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_dest(cmt_dest),
        .cmt_value(cmt_value), .cmt_is_store(cmt_is_store),
        .flush(flush), .occupancy(occupancy)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Move to the next falling edge and return all inputs to idle.
    task automatic nxt();
        @(negedge clk);
        alloc_req = 0; alloc_dest = 0; alloc_is_store = 0;
        cdb_valid = 0; cdb_tag = 0; cdb_value = 0;
        cdb_mispredict = 0; cdb_exception = 0;
    endtask

    task automatic do_alloc(input logic [4:0] d, input logic st, input logic [2:0] exp_tag, input string what);
        nxt();
        alloc_req = 1; alloc_dest = d; alloc_is_store = st;
        #1 chk(what, alloc_tag, exp_tag);
    endtask

    task automatic do_cdb(input logic [2:0] t, input logic [31:0] v, input logic mp, input logic ex);
        nxt();
        cdb_valid = 1; cdb_tag = t; cdb_value = v; cdb_mispredict = mp; cdb_exception = ex;
    endtask

    task automatic look(input logic [4:0] r, input logic busy, input logic [2:0] t, input string what);
        lk_reg = r;
        #1;
        chk({what, " busy"}, lk_busy, busy);
        if (busy) chk({what, " tag"}, lk_tag, t);
    endtask

    initial begin
        lk_reg = 0;
        nxt();
        nxt();
        nxt();
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 occupancy", occupancy, 0);
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 cmt_valid", cmt_valid, 0);
        chk("R1 flush", flush, 0);
        for (int r = 0; r < 32; r++) look(5'(r), 0, 0, "R1 reg idle");

        // R2/R3: fill all slots, slot 5 is a store
        for (int i = 0; i < 8; i++) do_alloc(5'(i + 1), i == 5, 3'(i), "R2 alloc tag");
        nxt();
        #1;
        chk("R2 full occupancy", occupancy, 8);
        chk("R2 full alloc_ready", alloc_ready, 0);
        alloc_req = 1; alloc_dest = 20;
        nxt();
        #1;
        chk("R2 refused occupancy", occupancy, 8);
        look(20, 0, 0, "R2 refused no rename");
        look(3, 1, 2, "R3 rename reg3");
        look(6, 0, 0, "R3 store not renamed");

        // R4/R5: results arrive in reverse order, head unfinished
        for (int t = 7; t >= 1; t--) begin
            do_cdb(3'(t), 32'(100 + t), 0, 0);
            nxt();
            #1;
            chk("R5 no retire before head", cmt_valid, 0);
        end
        look(8, 1, 7, "R4 status kept");
        chk("R4 ready", lk_ready, 1);
        chk("R4 value", lk_value, 107);
        look(1, 1, 0, "R4 head pending");
        chk("R4 head not ready", lk_ready, 0);

        // R5/R6: head finishes, all drain in order
        do_cdb(0, 100, 0, 0);
        for (int k = 0; k < 8; k++) begin
            nxt();
            #1;
            chk("R5 retire valid", cmt_valid, 1);
            chk("R5 retire order", cmt_tag, k);
            chk("R6 retire value", cmt_value, 100 + k);
            chk("R6 retire store", cmt_is_store, k == 5);
            if (k != 5) chk("R6 retire dest", cmt_dest, k + 1);
        end
        nxt();
        #1;
        chk("R6 drained", occupancy, 0);
        chk("R6 no retire", cmt_valid, 0);
        for (int r = 1; r <= 8; r++) look(5'(r), 0, 0, "R6 released");

        // R7: two renames of reg 9
        do_alloc(9, 0, 0, "R7 first tag");
        do_alloc(9, 0, 1, "R7 second tag");
        do_cdb(0, 55, 0, 0);
        nxt();
        #1;
        chk("R7 retire first", cmt_tag, 0);
        chk("R7 retire value", cmt_value, 55);
        nxt();
        look(9, 1, 1, "R7 newer rename kept");
        do_cdb(1, 66, 0, 0);
        nxt();
        #1;
        chk("R7 retire second", cmt_valid, 1);
        nxt();
        look(9, 0, 0, "R7 released");

        // R8: allocation during a retirement
        do_alloc(4, 0, 2, "R8 tag2");
        do_alloc(5, 0, 3, "R8 tag3");
        do_cdb(2, 77, 0, 0);
        nxt();
        alloc_req = 1; alloc_dest = 6;
        #1;
        chk("R8 retiring", cmt_valid, 1);
        chk("R8 before", occupancy, 2);
        chk("R8 new tag", alloc_tag, 4);
        nxt();
        #1;
        chk("R8 occupancy kept", occupancy, 2);
        look(4, 0, 0, "R8 reg4 released");
        look(6, 1, 4, "R8 reg6 renamed");
        do_cdb(3, 1, 0, 0);
        do_cdb(4, 2, 0, 0);
        nxt();
        nxt();
        #1;
        chk("R8 drained", occupancy, 0);

        // R10: stray write to an empty slot
        do_cdb(5, 999, 0, 0);
        do_alloc(11, 0, 5, "R10 tag5");
        nxt();
        look(11, 1, 5, "R10 renamed");
        chk("R10 not ready", lk_ready, 0);
        chk("R10 no retire", cmt_valid, 0);
        nxt();
        #1;
        chk("R10 still no retire", cmt_valid, 0);
        do_cdb(5, 123, 0, 0);
        nxt();
        #1;
        chk("R10 real result", cmt_value, 123);

        // R9: misprediction flush
        do_alloc(12, 0, 6, "R9 tag6");
        do_alloc(13, 0, 7, "R9 tag7");
        do_alloc(14, 0, 0, "R9 tag0");
        do_cdb(7, 1, 0, 0);
        do_cdb(6, 2, 1, 0);
        nxt();
        alloc_req = 1; alloc_dest = 15;
        #1;
        chk("R9 flush", flush, 1);
        chk("R9 no retire", cmt_valid, 0);
        chk("R9 refuse", alloc_ready, 0);
        nxt();
        #1;
        chk("R9 flush one cycle", flush, 0);
        chk("R9 emptied", occupancy, 0);
        for (int r = 12; r <= 15; r++) look(5'(r), 0, 0, "R9 status cleared");

        // R9: fault flush after one good retirement
        do_alloc(16, 0, 0, "R9 restart tag0");
        do_alloc(17, 0, 1, "R9 tag1");
        do_cdb(0, 5, 0, 0);
        nxt();
        cdb_valid = 1; cdb_tag = 1; cdb_value = 9; cdb_exception = 1;
        #1;
        chk("R9 good retire first", cmt_valid, 1);
        look(17, 1, 1, "R9 pending fault");
        nxt();
        #1;
        chk("R9 fault flush", flush, 1);
        nxt();
        #1;
        chk("R9 fault emptied", occupancy, 0);
        look(17, 0, 0, "R9 fault cleared");

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule